// File: doc/BRIEF.md
# Converter Result Serial Readout Port

This block is the device-side output port through which a host reads a finished conversion result. When the conversion sequencer reports a completed conversion, the port captures the 12-bit result into a 16-bit outgoing frame. The frame is four zero bits followed by the result, most significant bit first. The port then enables its tri-state driver. The host supplies the serial clock. The port moves the data line to the next bit on each falling edge of that clock, so the host can sample a bit on the same falling edge that retires it.

The serial clock comes from outside the system clock domain. It is oversampled through a synchroniser and reduced to a one-cycle falling-edge strobe. After the sixteenth falling edge, the last bit stays on the line for a set number of system clocks. The output enable then drops, and the line stays released until the next result is loaded. The result input may change while a conversion is in progress. The frame being shifted keeps the previous result, because the frame is reloaded only on the completion strobe. The serial clock is expected to idle low between transfers.

Top module: `adc_serial_readout`

## Requirements
- R1: While reset is held and right after it is released, `sdata_oe` is 0 and `sdata_o` is 0.
- R2: One system clock after `result_load` is sampled high, `sdata_oe` is 1. The frame is then 16 bits. Frame bits 15..12 are zero and bits 11..0 equal the `result_data` value captured with the load. Bit 15 is on `sdata_o` first.
- R3: Each falling edge of `sclk_in` advances `sdata_o` by one frame bit, from bit 15 towards bit 0. Rising edges of `sclk_in` leave `sdata_o` unchanged.
- R4: On the sixteenth falling edge, frame bit 0 stays on `sdata_o` with `sdata_oe` at 1 for HOLD_CYCLES system clocks. On the following clock, `sdata_oe` goes to 0.
- R5: After a frame has ended, further `sclk_in` edges keep `sdata_oe` at 0 until the next `result_load`.
- R6: Changes on `result_data` without `result_load` do not alter the frame being shifted. They also do not re-enable the output after a frame has ended.
- R7: A `result_load` in the middle of a frame discards the rest of that frame. The port restarts at frame bit 15 of the new result.
- R8: Whenever `sdata_oe` is 0, `sdata_o` is 0.
- R9: The falling edge of `sclk_in` is first visible on `sdata_o` after SYNC_STAGES+1 rising edges of `clk`. It is not visible after SYNC_STAGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| result_load | input | 1 | One-cycle strobe: conversion complete, capture `result_data` |
| result_data | input | DATA_W | Conversion result from the sequencer |
| sclk_in | input | 1 | Serial clock from the host, asynchronous, idles low |
| sdata_o | output | 1 | Serial data towards the tri-state pad driver |
| sdata_oe | output | 1 | Enable of the tri-state pad driver |

## Verification
A wrong bit counter shows at the ports within one serial clock period. Either a bit appears one position early or late, or the enable drops before or after the sixteenth edge plus the hold window. A stray reload or a missed capture shows at the next falling edge as a bit that does not match the expected frame. An enable that fails to stay low after a frame shows on the first extra clock edge the host sends. The synchroniser depth is pinned by sampling one clock before and one clock after the point where an edge may first appear.

// File: rtl/readout_pkg.sv
package readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } rd_state_e;

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic sclk_async,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= sclk_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~stage_q[SYNC_STAGES-1];

  // R3: a falling strobe never lasts two cycles in a row
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/readout_frame_ctrl.sv
module readout_frame_ctrl
  import readout_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int HOLD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic load_i,
  input  logic fall_i,
  output logic shift_en_o,
  output logic oe_o
);

  localparam int CNT_W  = $clog2(FRAME_W);
  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  LAST_FALL = CNT_W'(FRAME_W - 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYCLES - 1);

  rd_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              ctrl_en;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    hold_d     = hold_q;
    shift_en_o = 1'b0;
    if (load_i) begin
      state_d = ST_SHIFT;
      cnt_d   = '0;
      hold_d  = '0;
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          if (fall_i) begin
            if (cnt_q == LAST_FALL) begin
              state_d = ST_HOLD;
              hold_d  = HOLD_INIT;
            end else begin
              shift_en_o = 1'b1;
              cnt_d      = cnt_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (hold_q == '0) state_d = ST_IDLE;
          else              hold_d  = hold_q - 1'b1;
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  assign ctrl_en = load_i | fall_i | (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else if (ctrl_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
    end
  end

  assign oe_o = (state_q != ST_IDLE);

  // R2 / R7: a load always restarts at the first frame bit
  a_r7_load_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (state_q == ST_SHIFT && cnt_q == '0));

  // R3: every falling strobe before the last advances the bit count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SHIFT && fall_i && !load_i && cnt_q != LAST_FALL)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R4: the hold window ends by releasing the line
  a_r4_hold_to_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HOLD && hold_q == '0 && !load_i) |=> (state_q == ST_IDLE));

  // R5: once released, only a load re-enables the line
  a_r5_idle_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && !load_i) |=> !oe_o);

endmodule

// File: rtl/readout_shifter.sv
module readout_shifter #(
  parameter int DATA_W = 12,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              msb_o
);

  localparam int FRAME_W = DATA_W + PAD_W;

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;

  always_comb begin
    frame_d = frame_q;
    if (load_i)          frame_d = {{PAD_W{1'b0}}, data_i};
    else if (shift_en_i) frame_d = {frame_q[FRAME_W-2:0], 1'b0};
  end

  assign frame_en = load_i | shift_en_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= '0;
    else if (frame_en) frame_q <= frame_d;
  end

  assign msb_o = frame_q[FRAME_W-1];

  // R2: captured frame carries the zero pad above the result
  a_r2_pad_and_data: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (frame_q[FRAME_W-1 -: PAD_W] == '0 &&
                frame_q[DATA_W-1:0] == $past(data_i)));

  // R3: a shift moves the next lower bit to the line
  a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_en_i && !load_i) |=> (frame_q[FRAME_W-1] == $past(frame_q[FRAME_W-2])));

  // R6: without load or shift the frame does not move, whatever data_i does
  a_r6_frame_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && !shift_en_i) |=> $stable(frame_q));

endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout #(
  parameter int DATA_W      = 12,
  parameter int PAD_W       = 4,
  parameter int HOLD_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              result_load,
  input  logic [DATA_W-1:0] result_data,
  input  logic              sclk_in,
  output logic              sdata_o,
  output logic              sdata_oe
);

  localparam int FRAME_W = DATA_W + PAD_W;

  logic rst_meta_q, rst_sync_q;
  logic sclk_fall;
  logic shift_en;
  logic line_oe;
  logic frame_msb;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sclk_edge_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_sync (
    .clk        (clk),
    .rst_ni     (rst_sync_q),
    .sclk_async (sclk_in),
    .fall_o     (sclk_fall)
  );

  readout_frame_ctrl #(
    .FRAME_W     (FRAME_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_ctrl (
    .clk        (clk),
    .rst_ni     (rst_sync_q),
    .load_i     (result_load),
    .fall_i     (sclk_fall),
    .shift_en_o (shift_en),
    .oe_o       (line_oe)
  );

  readout_shifter #(
    .DATA_W (DATA_W),
    .PAD_W  (PAD_W)
  ) i_shift (
    .clk        (clk),
    .rst_ni     (rst_sync_q),
    .load_i     (result_load),
    .shift_en_i (shift_en),
    .data_i     (result_data),
    .msb_o      (frame_msb)
  );

  assign sdata_oe = line_oe;
  assign sdata_o  = line_oe & frame_msb;

  // R2: the line is enabled the cycle after a load, starting on a pad zero
  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_sync_q)
    result_load |=> (sdata_oe && !sdata_o));

endmodule

// File: tb/test_adc_serial_readout.sv
module test_adc_serial_readout;

  localparam int DATA_W = 12;
  localparam int PAD_W  = 4;
  localparam int FRAME_W = DATA_W + PAD_W;
  localparam int HOLD   = 3;
  localparam int SYNC   = 2;
  localparam int PH     = 4;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              result_load;
  logic [DATA_W-1:0] result_data;
  logic              sclk_in;
  logic              sdata_o;
  logic              sdata_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adc_serial_readout #(
    .DATA_W      (DATA_W),
    .PAD_W       (PAD_W),
    .HOLD_CYCLES (HOLD),
    .SYNC_STAGES (SYNC)
  ) i_adc_serial_readout (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .result_load (result_load),
    .result_data (result_data),
    .sclk_in     (sclk_in),
    .sdata_o     (sdata_o),
    .sdata_oe    (sdata_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frame_bit(input int v, input int idx);
    int fr;
    fr = v % (1 << DATA_W);
    return (fr >> idx) & 1;
  endfunction

  task automatic load_value(input int v);
    result_data = DATA_W'(v);
    result_load = 1'b1;
    tick(1);
    result_load = 1'b0;
    check_eq("R2 oe after load", int'(sdata_oe), 1);
    check_eq("R2 first pad bit", int'(sdata_o), 0);
  endtask

  task automatic one_fall();
    sclk_in = 1'b1;
    tick(PH);
    sclk_in = 1'b0;
    tick(PH);
  endtask

  task automatic read_frame(input int v);
    for (int k = 0; k < FRAME_W - 1; k++) begin
      check_eq("R2 R3 frame bit", int'(sdata_o), frame_bit(v, FRAME_W - 1 - k));
      check_eq("R3 oe in frame", int'(sdata_oe), 1);
      sclk_in = 1'b1;
      tick(PH);
      check_eq("R3 rising edge ignored", int'(sdata_o), frame_bit(v, FRAME_W - 1 - k));
      sclk_in = 1'b0;
      tick(PH);
    end
    check_eq("R3 last bit", int'(sdata_o), frame_bit(v, 0));
    sclk_in = 1'b1;
    tick(PH);
    sclk_in = 1'b0;
    tick(SYNC + HOLD);
    check_eq("R4 hold oe", int'(sdata_oe), 1);
    check_eq("R4 hold bit0", int'(sdata_o), frame_bit(v, 0));
    tick(1);
    check_eq("R4 released", int'(sdata_oe), 0);
    check_eq("R8 quiet when released", int'(sdata_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni      = 1'b0;
    result_load = 1'b0;
    result_data = '0;
    sclk_in     = 1'b0;
    tick(3);
    check_eq("R1 oe in reset", int'(sdata_oe), 0);
    check_eq("R1 data in reset", int'(sdata_o), 0);
    rst_ni = 1'b1;
    tick(4);
    check_eq("R1 oe after reset", int'(sdata_oe), 0);
    check_eq("R8 data after reset", int'(sdata_o), 0);

    // R2 R3 R4: corner patterns, walking ones, then a stride sweep
    load_value(0);      read_frame(0);
    load_value(4095);   read_frame(4095);
    load_value(12'hAAA); read_frame(12'hAAA);
    load_value(12'h555); read_frame(12'h555);
    for (int b = 0; b < DATA_W; b++) begin
      load_value(1 << b);
      read_frame(1 << b);
    end
    for (int v = 3; v < (1 << DATA_W); v += 17) begin
      load_value(v);
      read_frame(v);
    end

    // R5: extra edges after the frame keep the line released
    for (int e = 0; e < 5; e++) begin
      one_fall();
      check_eq("R5 extra edge", int'(sdata_oe), 0);
      check_eq("R8 extra edge data", int'(sdata_o), 0);
    end

    // R6: result changes while converting do not reach the frame or the line
    result_data = 12'h3C5;
    tick(PH);
    one_fall();
    check_eq("R6 no reload without strobe", int'(sdata_oe), 0);
    load_value(12'h9A6);
    result_data = 12'h165;
    one_fall();
    one_fall();
    result_data = 12'hE0F;
    for (int k = 2; k < FRAME_W - 1; k++) begin
      check_eq("R6 old frame kept", int'(sdata_o), frame_bit(12'h9A6, FRAME_W - 1 - k));
      one_fall();
    end
    check_eq("R6 old frame bit0", int'(sdata_o), frame_bit(12'h9A6, 0));
    one_fall();
    tick(2);
    check_eq("R6 R4 frame ended", int'(sdata_oe), 0);

    // R7: reload in mid-frame restarts with the new value
    load_value(12'hFFF);
    for (int k = 0; k < 6; k++) one_fall();
    check_eq("R7 mid-frame bit", int'(sdata_o), 1);
    load_value(12'h4B1);
    read_frame(12'h4B1);

    // R9: synchroniser latency on the first data bit of 0x800
    load_value(12'h800);
    for (int k = 0; k < PAD_W - 1; k++) one_fall();
    check_eq("R9 pad before edge", int'(sdata_o), 0);
    sclk_in = 1'b1;
    tick(PH);
    sclk_in = 1'b0;
    tick(SYNC);
    check_eq("R9 not yet visible", int'(sdata_o), 0);
    tick(1);
    check_eq("R9 visible", int'(sdata_o), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule